// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block brings up a target FPGA through its passive serial configuration port. When a load is requested, it pulls the active-low configuration request line low for a timed reset pulse. It then confirms that the target has answered on its active-low status line. After releasing the request line, it polls the status line at a fixed interval until the target signals that it is ready, and gives up after a bounded number of polls.

Once the target is ready, the block accepts bitstream bytes on a valid/ready stream and shifts each one out on a clock and data pair, bit 0 first. A byte marked as the last one ends the stream. The block then samples the status line one more time and reports either done or a configuration error.

The byte stream follows the usual back-pressure rules. A byte moves only on a cycle where both `byte_valid_i` and `byte_ready_o` are high. `byte_ready_o` stays low during the reset pulse, during polling and while a byte is being shifted. A producer may hold `byte_valid_i` low for as long as it likes, and the serial clock simply rests low until the next byte arrives. All timing comes from the `CLK_HZ` parameter. The serial clock half-period is `SCK_HALF` system cycles, and it must be chosen so that the serial clock stays at or below 20 MHz.

Top module: `ps_cfg_loader`

## Requirements
- R1: Out of reset, `cfg_n_o` is high and `dclk_o` is low. `busy_o`, `done_o`, `err_o` and `byte_ready_o` are all low.
- R2: A start pulse from idle with `partial_i` high is rejected in the next cycle. The block sets `err_o` with `err_code_o` = 2'b11, `cfg_n_o` never goes low, and `busy_o` stays low.
- R3: An accepted start drives `cfg_n_o` low for at least RESET_US microseconds (RESET_CYC system cycles), and for no more than one cycle beyond that.
- R4: If `status_n_i` reads high at the end of the reset pulse, the load ends with `err_o` set and `err_code_o` = 2'b00. In that case no serial clock edge is produced.
- R5: After `cfg_n_o` is released, status is sampled every POLL_US microseconds. Streaming (`byte_ready_o`) starts only after status reads high, and at the first poll that sees it high.
- R6: If status is still low after POLL_MAX polls, the load ends with `err_o` set and `err_code_o` = 2'b01, POLL_MAX*POLL_CYC cycles after release. No data is sent.
- R7: Each accepted byte produces 8 rising edges of `dclk_o`, with bit 0 presented first. `data_o` changes only while `dclk_o` is low and holds steady while it is high.
- R8: A byte is taken only on a cycle where valid and ready are both high. Ready is low while a byte is shifting. While no byte is offered, `dclk_o` rests low.
- R9: When the byte flagged last has been shifted, status is checked. If status is low, the block reports `err_o` with `err_code_o` = 2'b10. If status is high, it reports `done_o`.
- R10: `done_o` and `err_o` are never high together. Both stay set, with `cfg_n_o` high, until a new non-partial start is accepted from idle, which clears them.
- R11: The rising edges of `dclk_o` within a byte are exactly 2*SCK_HALF system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a load (taken only in idle) |
| partial_i | input | 1 | Marks the request as partial reconfiguration (rejected) |
| cfg_n_o | output | 1 | Active-low configuration request to the target |
| status_n_i | input | 1 | Active-low status from the target (asynchronous) |
| dclk_o | output | 1 | Serial configuration clock |
| data_o | output | 1 | Serial configuration data, bit 0 first |
| byte_data_i | input | 8 | Bitstream byte |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_ready_o | output | 1 | Byte stream ready |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load completed without error (sticky) |
| err_o | output | 1 | Last request ended in error (sticky) |
| err_code_o | output | 2 | 00 reset check, 01 ready timeout, 10 config error, 11 rejected |

## Verification
The stream is driven with bytes that tell bit orders apart: 8'h01 and 8'h80 reveal a reversed shift direction, and 8'hA5 and 8'h3C catch swapped or dropped bits. The bytes go in with no gap, short gaps and a long stall, so that ready handling and a resting serial clock are both exercised. The target is modelled through `status_n_i` in four ways: it never answers the reset pulse, it never leaves the asserted state, it becomes ready after a few polls, or it re-asserts status before the end of the stream. Each of these gives a different error code or done result, and each has its own timing window to check.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESET,
    ST_POLL,
    ST_STREAM
  } ps_state_t;

  localparam logic [1:0] ERR_RST_CHK = 2'b00;
  localparam logic [1:0] ERR_TIMEOUT = 2'b01;
  localparam logic [1:0] ERR_CFG     = 2'b10;
  localparam logic [1:0] ERR_REJECT  = 2'b11;
endpackage

// File: rtl/ps_sync2.sv
module ps_sync2 #(
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ps_tick_timer.sv
module ps_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ps_lsb_serializer.sv
module ps_lsb_serializer #(
  parameter int SCK_HALF = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              end_o
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = $clog2(BYTE_W);
  localparam logic [DW-1:0] DIV_TOP = DW'(SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_TOP = BW'(BYTE_W - 1);

  logic              busy_q;
  logic              last_q;
  logic              sck_q;
  logic              end_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     bit_q;
  logic [DW-1:0]     div_q;
  logic              take;

  assign in_ready_o = en_i && !busy_q;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      sck_q  <= 1'b0;
      end_q  <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      end_q <= 1'b0;
      if (take) begin
        sh_q   <= in_data_i;
        last_q <= in_last_i;
        busy_q <= 1'b1;
        bit_q  <= '0;
        div_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DIV_TOP) begin
          div_q <= '0;
          sck_q <= ~sck_q;
          if (sck_q) begin
            // falling edge: advance to the next bit or finish the byte
            if (bit_q == BIT_TOP) begin
              busy_q <= 1'b0;
              end_q  <= last_q;
            end else begin
              sh_q  <= sh_q >> 1;
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sck_o = sck_q;
  assign sdo_o = sh_q[0];
  assign end_o = end_q;
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int RESET_US = 50,
  parameter int POLL_US  = 50,
  parameter int POLL_MAX = 20,
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  output logic       cfg_n_o,
  input  logic       status_n_i,
  output logic       dclk_o,
  output logic       data_o,
  input  logic [7:0] byte_data_i,
  input  logic       byte_last_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int RESET_CYC  = RESET_US * CYC_PER_US;
  localparam int POLL_CYC   = POLL_US * CYC_PER_US;
  localparam int MAX_CYC    = (RESET_CYC > POLL_CYC) ? RESET_CYC : POLL_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam int PW         = $clog2(POLL_MAX + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

  ps_state_t   state_q;
  logic        stat_n_s;
  logic        tmr_load;
  logic [TW-1:0] tmr_val;
  logic        tmr_exp;
  logic        ser_end;
  logic [PW-1:0] polls_q;
  logic        done_q;
  logic        err_q;
  logic [1:0]  code_q;
  logic        start_ok;

  ps_sync2 #(.RESET_VAL(1'b1)) i_stat_sync (
    .clk(clk), .rst_n(rst_n), .d_i(status_n_i), .q_o(stat_n_s)
  );

  assign start_ok = (state_q == ST_IDLE) && start_i && !partial_i;
  assign tmr_load = start_ok
                 || (state_q == ST_RESET && tmr_exp && !stat_n_s)
                 || (state_q == ST_POLL && tmr_exp && !stat_n_s && polls_q != POLL_LAST);
  assign tmr_val  = (state_q == ST_IDLE) ? TW'(RESET_CYC - 1) : TW'(POLL_CYC - 1);

  ps_tick_timer #(.W(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  ps_lsb_serializer #(.SCK_HALF(SCK_HALF), .BYTE_W(8)) i_ser (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_STREAM),
    .in_data_i(byte_data_i), .in_last_i(byte_last_i),
    .in_valid_i(byte_valid_i), .in_ready_o(byte_ready_o),
    .sck_o(dclk_o), .sdo_o(data_o), .end_o(ser_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      polls_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_RST_CHK;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            done_q <= 1'b0;
            if (partial_i) begin
              err_q  <= 1'b1;
              code_q <= ERR_REJECT;
            end else begin
              err_q   <= 1'b0;
              state_q <= ST_RESET;
            end
          end
        end
        ST_RESET: begin
          if (tmr_exp) begin
            if (stat_n_s) begin
              err_q   <= 1'b1;
              code_q  <= ERR_RST_CHK;
              state_q <= ST_IDLE;
            end else begin
              polls_q <= '0;
              state_q <= ST_POLL;
            end
          end
        end
        ST_POLL: begin
          if (tmr_exp) begin
            if (stat_n_s) begin
              state_q <= ST_STREAM;
            end else if (polls_q == POLL_LAST) begin
              err_q   <= 1'b1;
              code_q  <= ERR_TIMEOUT;
              state_q <= ST_IDLE;
            end else begin
              polls_q <= polls_q + 1'b1;
            end
          end
        end
        ST_STREAM: begin
          if (ser_end) begin
            if (!stat_n_s) begin
              err_q  <= 1'b1;
              code_q <= ERR_CFG;
            end else begin
              done_q <= 1'b1;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_n_o    = (state_q != ST_RESET);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/ps_cfg_checker.sv
module ps_cfg_checker #(
  parameter int RESET_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       partial_i,
  input logic       cfg_n_o,
  input logic       dclk_o,
  input logic       data_o,
  input logic       byte_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= 0;
    else if (cfg_n_o) low_cnt <= 0;
    else low_cnt <= low_cnt + 1;
  end

  // R2
  partial_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && partial_i && !busy_o) |=> (err_o && err_code_o == 2'b11 && !busy_o && cfg_n_o));

  // R3
  reset_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_n_o && !$past(cfg_n_o)) |-> (low_cnt >= RESET_CYC));

  // R3
  pulse_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n_o |-> busy_o);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_o |-> $stable(data_o));

  // R8
  ready_when_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && cfg_n_o && !dclk_o));

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R10
  err_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> cfg_n_o);
endmodule

bind ps_cfg_loader ps_cfg_checker #(.RESET_CYC(RESET_CYC)) i_ps_cfg_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
  .cfg_n_o(cfg_n_o), .dclk_o(dclk_o), .data_o(data_o),
  .byte_ready_o(byte_ready_o), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/test_ps_cfg_loader.sv
module test_ps_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int RESET_CYC  = 50;
  localparam int POLL_CYC   = 50;
  localparam int POLL_MAX   = 20;
  localparam int SCK_HALF   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       partial_i = 1'b0;
  logic       cfg_n_o;
  logic       status_n_i = 1'b1;
  logic       dclk_o;
  logic       data_o;
  logic [7:0] byte_data_i = '0;
  logic       byte_last_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic       byte_ready_o;
  logic       busy_o;
  logic       done_o;
  logic       err_o;
  logic [1:0] err_code_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rises = 0;
  int bytes_seen = 0;
  int spacing_bad = 0;
  int last_rise = 0;
  int bitpos = 0;
  logic [7:0] acc = '0;
  logic prev_dclk = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_loader #(
    .CLK_HZ(CLK_HZ), .RESET_US(50), .POLL_US(50), .POLL_MAX(POLL_MAX),
    .SCK_HALF(SCK_HALF)
  ) i_ps_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
    .cfg_n_o(cfg_n_o), .status_n_i(status_n_i), .dclk_o(dclk_o),
    .data_o(data_o), .byte_data_i(byte_data_i), .byte_last_i(byte_last_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: rebuild bytes from rising serial clock edges, bit 0 first
  always @(negedge clk) begin
    cyc++;
    if (rst_n && dclk_o && !prev_dclk) begin
      rises++;
      if (bitpos != 0 && (cyc - last_rise) != 2*SCK_HALF) spacing_bad++;
      last_rise = cyc;
      acc = {data_o, acc[7:1]};
      bitpos++;
      if (bitpos == 8) begin
        bitpos = 0;
        bytes_seen++;
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected byte", acc, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(acc == e, "R7 byte order", acc, e);
        end
      end
    end
    prev_dclk = dclk_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic pulse_start(input bit part);
    @(negedge clk);
    start_i = 1'b1;
    partial_i = part;
    @(negedge clk);
    start_i = 1'b0;
    partial_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last, input int gap);
    exp_q.push_back(b);
    @(negedge clk);
    byte_data_i = b;
    byte_last_i = last;
    byte_valid_i = 1'b1;
    while (!byte_ready_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    byte_valid_i = 1'b0;
    byte_last_i = 1'b0;
    check(!byte_ready_o, "R8 ready low while shifting", byte_ready_o, 0);
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_release_after_pulse();
    while (!cfg_n_o) @(negedge clk);
  endtask

  initial begin
    int lowc;
    int tcnt;
    int r0;
    bit early;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_n_o && !dclk_o, "R1 pins idle", {cfg_n_o, dclk_o}, 2'b10);
    check(!busy_o && !done_o && !err_o && !byte_ready_o, "R1 flags clear",
          {busy_o, done_o, err_o, byte_ready_o}, 0);

    // R2 partial request rejected, pins untouched
    r0 = rises;
    pulse_start(1'b1);
    check(err_o && err_code_o == 2'b11, "R2 reject code", {err_o, err_code_o}, 3'b111);
    lowc = 0;
    repeat (10) begin
      if (!cfg_n_o || busy_o) lowc++;
      @(negedge clk);
    end
    check(lowc == 0 && rises == r0, "R2 pins untouched", lowc, 0);

    // R3 / R4 target never answers the pulse
    status_n_i = 1'b1;
    r0 = rises;
    pulse_start(1'b0);
    check(!err_o && busy_o, "R10 start clears err", {err_o, busy_o}, 2'b01);
    lowc = 0;
    while (!cfg_n_o) begin lowc++; @(negedge clk); end
    check(lowc >= RESET_CYC && lowc <= RESET_CYC + 1, "R3 pulse width", lowc, RESET_CYC);
    check(err_o && err_code_o == 2'b00 && !busy_o, "R4 reset check code",
          {err_o, err_code_o, busy_o}, 3'b100);
    check(rises == r0, "R4 no serial clock", rises - r0, 0);

    // R6 target stuck in asserted status
    r0 = rises;
    pulse_start(1'b0);
    status_n_i = 1'b0;
    wait_release_after_pulse();
    tcnt = 0;
    early = 1'b0;
    while (!err_o && tcnt < 3000) begin
      if (byte_ready_o) early = 1'b1;
      tcnt++;
      @(negedge clk);
    end
    check(err_code_o == 2'b01 && err_o, "R6 timeout code", err_code_o, 2'b01);
    check(tcnt >= POLL_MAX*POLL_CYC && tcnt <= POLL_MAX*POLL_CYC + 2, "R6 timeout window",
          tcnt, POLL_MAX*POLL_CYC);
    check(!early && rises == r0, "R6 no data", rises - r0, 0);
    repeat (20) @(negedge clk);
    check(err_o && cfg_n_o && !busy_o, "R10 sticky err, released",
          {err_o, cfg_n_o, busy_o}, 3'b110);

    // R5, R7, R8, R9, R11 good load
    pulse_start(1'b0);
    status_n_i = 1'b0;
    wait_release_after_pulse();
    early = 1'b0;
    repeat (120) begin
      if (byte_ready_o) early = 1'b1;
      @(negedge clk);
    end
    check(!early, "R5 no ready before status", early, 0);
    status_n_i = 1'b1;
    tcnt = 0;
    while (!byte_ready_o && tcnt < 200) begin tcnt++; @(negedge clk); end
    check(tcnt > 0 && tcnt <= 32, "R5 ready at next poll", tcnt, 30);
    bytes_seen = 0;
    spacing_bad = 0;
    send_byte(8'hA5, 1'b0, 0);
    send_byte(8'h01, 1'b0, 3);
    send_byte(8'h80, 1'b0, 40);
    r0 = rises;
    repeat (20) begin
      if (dclk_o) early = 1'b1;
      @(negedge clk);
    end
    check(!early && rises == r0, "R8 clock rests while stalled", rises - r0, 0);
    send_byte(8'h3C, 1'b1, 0);
    while (busy_o) @(negedge clk);
    check(done_o && !err_o, "R9 done", {done_o, err_o}, 2'b10);
    check(bytes_seen == 4 && exp_q.size() == 0, "R7 byte count", bytes_seen, 4);
    check(spacing_bad == 0, "R11 clock spacing", spacing_bad, 0);

    // R9 status drops before the end of the stream
    pulse_start(1'b0);
    check(!done_o, "R10 start clears done", done_o, 0);
    status_n_i = 1'b0;
    wait_release_after_pulse();
    repeat (10) @(negedge clk);
    status_n_i = 1'b1;
    send_byte(8'h5A, 1'b0, 2);
    send_byte(8'hC3, 1'b1, 0);
    status_n_i = 1'b0;
    while (busy_o) @(negedge clk);
    check(err_o && err_code_o == 2'b10 && !done_o, "R9 config error",
          {err_o, err_code_o, done_o}, 3'b110);
    check(exp_q.size() == 0, "R7 all bytes out", exp_q.size(), 0);
    status_n_i = 1'b1;

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule